// File: doc/BRIEF.md
# Instruction Byte Prefetcher

This block keeps an external byte queue supplied with instruction bytes for a processor that uses 16-bit segmented addressing. It holds a code segment and a fetch pointer, and forms a 20-bit physical byte address from them. It reads 16-bit words through a request/acknowledge memory port that carries word addresses. Each word is split into bytes, and the bytes are written into the queue one per clock, low byte first.

A redirect loads a new segment and pointer. In the same cycle the block flushes the queue and points the memory address at the new location. A word read that is still outstanding is allowed to finish, but its data is thrown away. While the queue reports full, the block starts no new memory access and pushes no byte. When the queue has room again, fetching continues at the next byte that has not been fetched.

The controller has four states:
- `S_FETCH` issues or holds a word read.
- `S_DISCARD` waits for the acknowledge of a cancelled read.
- `S_LOW` pushes the low byte of the held word.
- `S_HIGH` pushes the high byte of the held word.

The transitions are:
- `S_FETCH` to `S_LOW` on an acknowledge when the pointer is even.
- `S_FETCH` to `S_HIGH` on an acknowledge when the pointer is odd.
- `S_FETCH` to `S_DISCARD` on a redirect while a read is pending without an acknowledge.
- `S_DISCARD` to `S_FETCH` on the acknowledge.
- `S_LOW` to `S_HIGH` on a push.
- `S_HIGH` to `S_FETCH` on a push.
- `S_LOW` and `S_HIGH` to `S_FETCH` on any redirect.

Top module: `ifetch_unit`

## Requirements
- R1: After a synchronous reset the segment is 0xFFFF and the pointer is 0x0000. While reset is high, no request and no push occur. The first request after reset uses word address 0x7FFF8.
- R2: The physical address is (segment × 16 + pointer) modulo 2^20. `mem_waddr` is that address shifted right by one whenever `mem_req` is high.
- R3: Each word is pushed as bits 7:0 first, then bits 15:8, on consecutive non-full clocks, following the pointer order.
- R4: When the pointer is odd at the time of the fetch, only bits 15:8 of that first word are pushed. The next read uses the following word address.
- R5: In the cycle `redirect` is high, `q_flush` is high, `q_push` is low, and `mem_waddr` already shows the new location. In all other cycles `q_flush` is low.
- R6: When a redirect arrives while a read is pending without an acknowledge, the data of that read is never pushed. Only bytes from the new location follow.
- R7: No read starts while `q_full` is high, and no byte is pushed while `q_full` is high.
- R8: After any full stall, the byte stream continues with no byte skipped or repeated.
- R9: In the cycle after the high byte of a word is pushed, a new read is requested if the queue is not full and no redirect is present. With a zero-latency memory this gives one word every three cycles.
- R10: Once raised, `mem_req` stays high until a cycle with `mem_ack` high.
- R11: The pointer wraps modulo 2^16 inside the segment. The segment does not change on the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| redirect | input | 1 | Load `seg_in`/`ptr_in` and flush |
| seg_in | input | 16 | New code segment |
| ptr_in | input | 16 | New fetch pointer |
| q_full | input | 1 | Byte queue cannot accept a byte |
| q_push | output | 1 | Write strobe for the byte queue |
| q_byte | output | 8 | Byte written to the queue |
| q_flush | output | 1 | Clear the byte queue |
| mem_req | output | 1 | Word read request |
| mem_waddr | output | 19 | Word address of the read |
| mem_ack | input | 1 | Single-cycle read acknowledge |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |

## Verification
Two events can fall in the same cycle: a redirect, and either a read acknowledge or a byte push. In that cycle the redirect must win. No push may happen, any data that arrives is dropped, and the address must already point at the new location. The bench provokes these collisions in two ways. It redirects a few cycles into a slow read. It also redirects at pseudo-random times while the memory latency and the full flag vary. Every clock, a behavioural byte-stream model checks each pushed byte against the byte expected at the model's own pointer. A stale byte therefore appears as a data mismatch.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
    typedef enum logic [1:0] {
        S_FETCH   = 2'd0,
        S_DISCARD = 2'd1,
        S_LOW     = 2'd2,
        S_HIGH    = 2'd3
    } ifu_state_e;
endpackage

// File: rtl/ifu_addr_gen.sv
module ifu_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    localparam int SUM_W = SEG_W + SHIFT;

    logic [SUM_W-1:0] seg_base;

    assign seg_base = {seg, {SHIFT{1'b0}}};
    assign phys     = PA_W'(seg_base) + PA_W'(off);
endmodule

// File: rtl/ifu_word_buf.sv
module ifu_word_buf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              hi_sel,
    output logic [7:0]        dout
);
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (load)
            word_q <= din;
    end

    assign dout = hi_sel ? word_q[DATA_W-1 -: 8] : word_q[7:0];
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
    import ifu_pkg::*;
#(
    parameter int               SEG_W     = 16,
    parameter int               OFF_W     = 16,
    parameter int               SHIFT     = 4,
    parameter int               DATA_W    = 16,
    parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
    parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redirect,
    input  logic [SEG_W-1:0]  seg_in,
    input  logic [OFF_W-1:0]  ptr_in,
    input  logic              q_full,
    output logic              q_push,
    output logic [7:0]        q_byte,
    output logic              q_flush,
    output logic              mem_req,
    output logic [SEG_W+SHIFT-2:0] mem_waddr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int PA_W = SEG_W + SHIFT;

    ifu_state_e       state_q, state_d;
    logic             in_flight_q, in_flight_d;
    logic [SEG_W-1:0] seg_q, seg_d;
    logic [OFF_W-1:0] ptr_q, ptr_d;
    logic             capture;
    logic [PA_W-1:0]  phys_cur, phys_new;

    ifu_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_cur_addr (
        .seg  (seg_q),
        .off  (ptr_q),
        .phys (phys_cur)
    );

    ifu_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_new_addr (
        .seg  (seg_in),
        .off  (ptr_in),
        .phys (phys_new)
    );

    ifu_word_buf #(.DATA_W(DATA_W)) u_word (
        .clk    (clk),
        .load   (capture),
        .din    (mem_rdata),
        .hi_sel (state_q == S_HIGH),
        .dout   (q_byte)
    );

    assign mem_waddr = redirect ? phys_new[PA_W-1:1] : phys_cur[PA_W-1:1];

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_FETCH;
            in_flight_q <= 1'b0;
            seg_q       <= RESET_SEG;
            ptr_q       <= RESET_OFF;
        end else begin
            state_q     <= state_d;
            in_flight_q <= in_flight_d;
            seg_q       <= seg_d;
            ptr_q       <= ptr_d;
        end
    end

    // Outputs
    always_comb begin
        q_flush = redirect && !rst;
        q_push  = 1'b0;
        mem_req = 1'b0;
        unique case (state_q)
            S_FETCH:   mem_req = !rst && (in_flight_q || (!q_full && !redirect));
            S_DISCARD: mem_req = !rst;
            S_LOW,
            S_HIGH:    q_push  = !rst && !q_full && !redirect;
            default:   mem_req = 1'b0;
        endcase
    end

    // Next state
    always_comb begin
        state_d     = state_q;
        in_flight_d = in_flight_q;
        seg_d       = seg_q;
        ptr_d       = ptr_q;
        capture     = 1'b0;
        if (redirect) begin
            seg_d = seg_in;
            ptr_d = ptr_in;
        end
        unique case (state_q)
            S_FETCH: begin
                if (redirect) begin
                    in_flight_d = 1'b0;
                    state_d     = (mem_req && !mem_ack) ? S_DISCARD : S_FETCH;
                end else if (mem_req && mem_ack) begin
                    capture     = 1'b1;
                    in_flight_d = 1'b0;
                    state_d     = ptr_q[0] ? S_HIGH : S_LOW;
                end else begin
                    in_flight_d = mem_req;
                end
            end
            S_DISCARD: begin
                if (mem_ack)
                    state_d = S_FETCH;
            end
            S_LOW: begin
                if (redirect)
                    state_d = S_FETCH;
                else if (q_push) begin
                    ptr_d   = ptr_q + OFF_W'(1);
                    state_d = S_HIGH;
                end
            end
            S_HIGH: begin
                if (redirect)
                    state_d = S_FETCH;
                else if (q_push) begin
                    ptr_d   = ptr_q + OFF_W'(1);
                    state_d = S_FETCH;
                end
            end
            default: state_d = S_FETCH;
        endcase
    end
endmodule

// File: rtl/ifu_checker.sv
module ifu_checker
    import ifu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       redirect,
    input logic       q_full,
    input logic       q_push,
    input logic       q_flush,
    input logic       mem_req,
    input logic       mem_ack,
    input ifu_state_e state_q
);
    assert_no_push_full_R7: assert property (@(posedge clk) disable iff (rst)
        q_push |-> !q_full);

    assert_no_start_full_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && q_full) |-> $past(mem_req && !mem_ack));

    assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    assert_flush_blocks_push_R5: assert property (@(posedge clk) disable iff (rst)
        q_flush |-> !q_push);

    assert_discard_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DISCARD) |-> !q_push);

    assert_next_word_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_HIGH && q_push) |=> (mem_req || q_full || redirect || rst));
endmodule

bind ifetch_unit ifu_checker u_ifu_checker (
    .clk      (clk),
    .rst      (rst),
    .redirect (redirect),
    .q_full   (q_full),
    .q_push   (q_push),
    .q_flush  (q_flush),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .state_q  (state_q)
);

// File: tb/test_ifetch_unit.sv
`timescale 1ns/1ps
module test_ifetch_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        redirect = 1'b0;
    logic [15:0] seg_in = 16'h0;
    logic [15:0] ptr_in = 16'h0;
    logic        q_full = 1'b0;
    logic        q_push;
    logic [7:0]  q_byte;
    logic        q_flush;
    logic        mem_req;
    logic [18:0] mem_waddr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'h0;

    int n_cmp = 0;
    int n_bad = 0;
    int lat = 0;
    int npush = 0;
    string cur_tag = "R3";

    always #10 clk = ~clk;

    ifetch_unit i_ifetch_unit (
        .clk(clk), .rst(rst), .redirect(redirect), .seg_in(seg_in), .ptr_in(ptr_in),
        .q_full(q_full), .q_push(q_push), .q_byte(q_byte), .q_flush(q_flush),
        .mem_req(mem_req), .mem_waddr(mem_waddr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'b0} + {4'b0, o};
    endfunction

    function automatic logic [7:0] mbyte(input logic [19:0] b);
        return b[7:0] ^ b[15:8] ^ {b[19:16], b[3:0]} ^ 8'h5A;
    endfunction

    function automatic logic [15:0] mword(input logic [18:0] w);
        return {mbyte({w, 1'b1}), mbyte({w, 1'b0})};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Memory responder: latches the address when a read starts
    logic        busy = 1'b0;
    logic [18:0] laddr = '0;
    int          cnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0; busy = 1'b0; cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (!busy) begin busy = 1'b1; laddr = mem_waddr; cnt = 0; end
            if (cnt >= lat) begin
                mem_ack = 1'b1; mem_rdata = mword(laddr); busy = 1'b0;
            end else cnt++;
        end
    end

    // Reference model, compared every clock just before the rising edge
    logic [15:0] exp_seg = 16'hFFFF;
    logic [15:0] exp_ptr = 16'h0;
    bit pend = 0, prev_hi = 0;
    always @(negedge clk) begin
        #8;
        if (rst) begin
            chk(!q_push, "R1", "push in reset", q_push, 0);
            chk(!mem_req, "R1", "req in reset", mem_req, 0);
            exp_seg = 16'hFFFF; exp_ptr = 16'h0; pend = 0; prev_hi = 0;
        end else begin
            if (pend) chk(mem_req, "R10", "req dropped before ack", mem_req, 1);
            if (mem_req && !pend && q_full) chk(0, "R7", "read started while full", 1, 0);
            if (prev_hi && !q_full && !redirect) chk(mem_req, "R9", "next word request", mem_req, 1);
            if (redirect) begin
                chk(q_flush, "R5", "flush on redirect", q_flush, 1);
                chk(!q_push, "R5", "push on redirect", q_push, 0);
                chk(mem_waddr == phys(seg_in, ptr_in) >> 1, "R5", "redirect address",
                    mem_waddr, phys(seg_in, ptr_in) >> 1);
                exp_seg = seg_in; exp_ptr = ptr_in; prev_hi = 0;
            end else begin
                chk(!q_flush, "R5", "stray flush", q_flush, 0);
                if (mem_req)
                    chk(mem_waddr == phys(exp_seg, exp_ptr) >> 1, "R2", "word address",
                        mem_waddr, phys(exp_seg, exp_ptr) >> 1);
                if (q_push) begin
                    chk(!q_full, "R7", "push while full", q_full, 0);
                    chk(q_byte == mbyte(phys(exp_seg, exp_ptr)), cur_tag, "byte",
                        q_byte, mbyte(phys(exp_seg, exp_ptr)));
                    prev_hi = exp_ptr[0];
                    exp_ptr = exp_ptr + 16'd1;
                    npush++;
                end else prev_hi = 0;
            end
            pend = mem_req && !mem_ack;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic jump(input logic [15:0] s, input logic [15:0] p, input string tag);
        redirect = 1'b1; seg_in = s; ptr_in = p; cur_tag = tag;
        tick(1);
        redirect = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        tick(3);
        rst = 1'b0;
        #14;
        chk(mem_req && mem_waddr == 19'h7FFF8, "R1", "first request", mem_waddr, 19'h7FFF8);
        tick(1);
        // R3 R9: zero-latency back-to-back stream
        npush = 0;
        tick(24);
        chk(npush >= 14, "R9", "pushes in 24 cycles", npush, 14);
        // R7 R8: full stalls with a slower memory
        lat = 2; cur_tag = "R8";
        q_full = 1'b1; tick(9); q_full = 1'b0; tick(3);
        for (int i = 0; i < 12; i++) begin q_full = i[0]; tick(1); end
        q_full = 1'b0; tick(10);
        // R4: odd pointer start
        lat = 0;
        jump(16'h1234, 16'h0101, "R4");
        npush = 0; tick(8);
        chk(npush >= 3, "R4", "progress after odd start", npush, 3);
        // R6: redirect during a slow read
        lat = 5;
        jump(16'hDEAD, 16'h0008, "R6");
        tick(2);
        jump(16'h0100, 16'h0033, "R6");
        npush = 0; tick(30);
        chk(npush >= 3, "R6", "progress after discard", npush, 3);
        // R11: pointer wrap inside the segment
        lat = 0;
        jump(16'h2000, 16'hFFFD, "R11");
        npush = 0; tick(15);
        chk(npush >= 6, "R11", "progress across wrap", npush, 6);
        // R2: physical address wraps at 2^20
        jump(16'hFFFF, 16'h0020, "R2");
        tick(12);
        // Mixed collisions of redirect, ack, push and full
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            q_full = (lfsr[1:0] == 2'b00);
            lat = int'(lfsr[5:4]);
            if (lfsr[9:6] == 4'h0) jump(lfsr, {lfsr[7:0], lfsr[15:8]}, "R6");
            else tick(1);
        end
        q_full = 1'b0; lat = 0;
        // R1: reset mid-stream
        rst = 1'b1; tick(2);
        rst = 1'b0;
        #14;
        chk(mem_req && mem_waddr == 19'h7FFF8, "R1", "request after reset", mem_waddr, 19'h7FFF8);
        tick(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule